// File: doc/BRIEF.md
# Speculative Branch Dispatch Controller

This block is the front-end steering stage of an in-order core. It takes pre-decoded instruction records from a sequential fetcher, buffers them in a small internal queue, and dispatches them to the execution units. Branches never use an issue slot. Unconditional jumps are folded out, and so are conditional branches whose outcome is already known. Either kind redirects the fetcher to the branch target when the branch is taken. Conditional branches that are still unresolved get a static guess. Work then continues on the guessed path.

While a guess is outstanding, integer, floating-point, memory and system operations still issue, but each carries a speculative mark. Their write-back is refused until the guess is resolved. Operations for the branch unit itself wait at the head of the queue. A resolution input settles the guess. A correct guess clears every speculative mark with no dispatch bubble. A wrong guess raises a one-cycle flush, empties the queue, cancels every speculative tag, and restarts fetch on the other path.

The record input and the issue output are valid/ready streams. `in_ready` is low only when the queue is full. Any beat accepted in a cycle with `redir_valid` high belongs to the abandoned path and is dropped. `iss_valid` does not depend on `iss_ready`. A presented operation holds its PC, unit and tag until it is taken, unless a flush removes it. The write-back port is also a handshake: a unit holds `wb_valid` with its tag until `wb_ready` grants it.

Top module: `spec_branch_dispatch`

## Requirements
- R1: After reset the queue is empty, `in_ready` is 1, `iss_valid`, `redir_valid` and `flush` are 0, no guess is outstanding, and no write-back is granted.
- R2: Operation kinds 0 (integer), 1 (float), 2 (memory), 3 (system) and 4 (branch-unit op) issue in queue order with `iss_unit` equal to the kind. An operation that is offered but not taken holds its PC, unit and tag on the following cycle.
- R3: Kind 5 (jump) consumes no issue slot. In the cycle it reaches the head, `redir_valid` is 1 and `redir_pc` is its PC plus the sign-extended 16-bit displacement. All younger queued records are discarded.
- R4: A kind 6 (conditional) record with `known`=1 is folded without a guess. If `outcome`=1 it redirects exactly like a jump. If `outcome`=0 it is dropped with no redirect, and the next record issues on the following cycle.
- R5: A kind 6 record with `known`=0 and no guess outstanding is guessed taken when (displacement bit 15) XOR `hint` is 1. A taken guess redirects to the target and clears the queue. A not-taken guess redirects nothing.
- R6: Every issued operation has `iss_spec` equal to 1 exactly when a guess is outstanding and unresolved in that cycle. `wb_ready` is 1 only for a live tag whose speculative mark is clear.
- R7: A branch-unit op (kind 4) at the head is not issued while a guess is outstanding.
- R8: An unresolved conditional at the head stalls while another guess is outstanding. It is guessed in the cycle the first guess resolves.
- R9: On `res_valid` with `res_taken` equal to the guess, `flush` stays 0. Dispatch in that cycle is non-speculative, and held write-backs are granted from the next cycle.
- R10: On `res_valid` with `res_taken` differing from the guess, `flush` and `redir_valid` are 1 for that cycle and nothing issues. `redir_pc` is the branch PC plus 4 if the guess was taken, or else the target. The queue is emptied, and speculative tags are never granted write-back.
- R11: Tags are handed out cyclically from 0 to NTAG-1. Issue stalls while the next tag is still awaiting write-back.
- R12: A record presented in a cycle where `redir_valid` is 1 is accepted and discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Record offered by the fetcher |
| in_ready | output | 1 | Queue has room |
| in_pc | input | PC_W | Record PC |
| in_disp | input | DISP_W | Signed branch displacement |
| in_kind | input | 3 | Record kind code (R2 to R5) |
| in_hint | input | 1 | Inverts the static guess |
| in_known | input | 1 | Condition already evaluated |
| in_outcome | input | 1 | Evaluated condition, 1 = taken |
| iss_valid | output | 1 | Operation offered to a unit |
| iss_ready | input | 1 | Unit accepts the operation |
| iss_pc | output | PC_W | PC of offered operation |
| iss_unit | output | 3 | Destination unit code |
| iss_tag | output | TAG_W | Tag assigned to the operation |
| iss_spec | output | 1 | Operation lies past an unresolved guess |
| wb_valid | input | 1 | A unit requests write-back |
| wb_tag | input | TAG_W | Tag of the requesting operation |
| wb_ready | output | 1 | Write-back granted |
| res_valid | input | 1 | Outstanding guess resolved this cycle |
| res_taken | input | 1 | Actual direction of that branch |
| flush | output | 1 | One-cycle misprediction flush |
| redir_valid | output | 1 | Fetcher must restart |
| redir_pc | output | PC_W | Restart address |

## Verification
The hardest case to reach is a write-back request for a speculative operation that sits behind a stalled branch-unit op and a second unresolved conditional, at the moment the guess resolves. The bench builds this case deliberately. It issues one guess, then pushes an integer op, a branch-unit op and a second conditional, and holds a write-back request on the integer op's tag. It then resolves the guess both ways for every combination of displacement sign, hint and actual direction. For each combination it checks the same-cycle issue, the flush and the restart address, and the grant on the following cycle. A separate run fills every tag so that issue must stall on tag reuse.

// File: rtl/sbd_pkg.sv
package sbd_pkg;
  parameter int PC_W   = 32;
  parameter int DISP_W = 16;

  typedef enum logic [2:0] {
    OP_INT = 3'd0,
    OP_FLT = 3'd1,
    OP_MEM = 3'd2,
    OP_SYS = 3'd3,
    OP_BRU = 3'd4,
    OP_JMP = 3'd5,
    OP_BCC = 3'd6
  } op_kind_e;

  typedef struct packed {
    logic [PC_W-1:0]   pc;
    logic [DISP_W-1:0] disp;
    logic [2:0]        kind;
    logic              hint;
    logic              known;
    logic              outcome;
  } rec_t;
endpackage

// File: rtl/sbd_queue.sv
module sbd_queue
  import sbd_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  rec_t push_rec,
  input  logic pop,
  input  logic clear,
  output rec_t head,
  output logic head_valid,
  output logic full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  rec_t          mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign head       = mem[rd_ptr];
  assign head_valid = (count != '0);
  assign full       = (count == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) begin
        mem[wr_ptr] <= push_rec;
        wr_ptr      <= bump(wr_ptr);
      end
      if (pop) rd_ptr <= bump(rd_ptr);
      count <= count + CW'(push) - CW'(pop);
    end
  end
endmodule

// File: rtl/sbd_steer.sv
module sbd_steer
  import sbd_pkg::*;
#(
  parameter int PC_STEP = 4
) (
  input  rec_t            head,
  input  logic            head_valid,
  input  logic            guess_open,
  input  logic            flush,
  input  logic            iss_ready,
  input  logic            tag_free,
  output logic            pop,
  output logic            issue_valid,
  output logic            fold_redir,
  output logic [PC_W-1:0] fold_pc,
  output logic            guess_set,
  output logic            guess_taken,
  output logic [PC_W-1:0] other_pc
);
  logic [PC_W-1:0] target, seq_pc;
  logic            back;

  assign target = head.pc + {{(PC_W-DISP_W){head.disp[DISP_W-1]}}, head.disp};
  assign seq_pc = head.pc + PC_W'(PC_STEP);
  assign back   = head.disp[DISP_W-1];
  assign fold_pc = target;

  always_comb begin
    pop         = 1'b0;
    issue_valid = 1'b0;
    fold_redir  = 1'b0;
    guess_set   = 1'b0;
    guess_taken = 1'b0;
    other_pc    = target;
    if (head_valid && !flush) begin
      case (head.kind)
        OP_JMP: begin
          pop        = 1'b1;
          fold_redir = 1'b1;
        end
        OP_BCC: begin
          if (head.known) begin
            pop        = 1'b1;
            fold_redir = head.outcome;
          end else if (!guess_open) begin
            pop         = 1'b1;
            guess_set   = 1'b1;
            guess_taken = back ^ head.hint;
            fold_redir  = back ^ head.hint;
            other_pc    = (back ^ head.hint) ? seq_pc : target;
          end
        end
        OP_BRU: issue_valid = !guess_open && tag_free;
        default: issue_valid = tag_free;
      endcase
      if (issue_valid && iss_ready) pop = 1'b1;
    end
  end
endmodule

// File: rtl/sbd_tags.sv
module sbd_tags #(
  parameter int NTAG = 8,
  localparam int TW = (NTAG > 1) ? $clog2(NTAG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc,
  input  logic          alloc_spec,
  input  logic          commit,
  input  logic          kill,
  input  logic          wb_valid,
  input  logic [TW-1:0] wb_tag,
  output logic [TW-1:0] next_tag,
  output logic          tag_free,
  output logic          wb_grant
);
  logic [NTAG-1:0] live, spec, live_n, spec_n;
  logic [TW-1:0]   ptr;

  assign next_tag = ptr;
  assign tag_free = !live[ptr];
  assign wb_grant = wb_valid && live[wb_tag] && !spec[wb_tag];

  always_comb begin
    live_n = live;
    spec_n = spec;
    if (commit) spec_n = '0;
    if (kill) begin
      live_n = live & ~spec;
      spec_n = '0;
    end
    if (wb_grant) live_n[wb_tag] = 1'b0;
    if (alloc) begin
      live_n[ptr] = 1'b1;
      spec_n[ptr] = alloc_spec;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live <= '0;
      spec <= '0;
      ptr  <= '0;
    end else begin
      live <= live_n;
      spec <= spec_n;
      if (alloc) ptr <= (ptr == TW'(NTAG - 1)) ? '0 : ptr + 1'b1;
    end
  end
endmodule

// File: rtl/spec_branch_dispatch.sv
module spec_branch_dispatch
  import sbd_pkg::*;
#(
  parameter int QDEPTH  = 4,
  parameter int NTAG    = 8,
  parameter int PC_STEP = 4,
  localparam int TAG_W = (NTAG > 1) ? $clog2(NTAG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PC_W-1:0]   in_pc,
  input  logic [DISP_W-1:0] in_disp,
  input  logic [2:0]        in_kind,
  input  logic              in_hint,
  input  logic              in_known,
  input  logic              in_outcome,
  output logic              iss_valid,
  input  logic              iss_ready,
  output logic [PC_W-1:0]   iss_pc,
  output logic [2:0]        iss_unit,
  output logic [TAG_W-1:0]  iss_tag,
  output logic              iss_spec,
  input  logic              wb_valid,
  input  logic [TAG_W-1:0]  wb_tag,
  output logic              wb_ready,
  input  logic              res_valid,
  input  logic              res_taken,
  output logic              flush,
  output logic              redir_valid,
  output logic [PC_W-1:0]   redir_pc
);
  rec_t            in_rec, head;
  logic            head_valid, q_full, q_pop, q_push;
  logic            open_q, guess_q;
  logic [PC_W-1:0] other_q;
  logic            guess_open, commit;
  logic            fold_redir, guess_set, guess_taken, tag_free;
  logic [PC_W-1:0] fold_pc, other_pc;

  assign in_rec = '{pc: in_pc, disp: in_disp, kind: in_kind,
                    hint: in_hint, known: in_known, outcome: in_outcome};

  assign flush       = res_valid && open_q && (res_taken != guess_q);
  assign commit      = res_valid && open_q && (res_taken == guess_q);
  assign guess_open  = open_q && !res_valid;
  assign redir_valid = flush || fold_redir;
  assign redir_pc    = flush ? other_q : fold_pc;
  assign in_ready    = !q_full;
  assign q_push      = in_valid && !q_full && !redir_valid;

  sbd_queue #(.DEPTH(QDEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(q_push), .push_rec(in_rec),
    .pop(q_pop), .clear(redir_valid), .head(head),
    .head_valid(head_valid), .full(q_full)
  );

  sbd_steer #(.PC_STEP(PC_STEP)) u_steer (
    .head(head), .head_valid(head_valid), .guess_open(guess_open),
    .flush(flush), .iss_ready(iss_ready), .tag_free(tag_free),
    .pop(q_pop), .issue_valid(iss_valid), .fold_redir(fold_redir),
    .fold_pc(fold_pc), .guess_set(guess_set), .guess_taken(guess_taken),
    .other_pc(other_pc)
  );

  sbd_tags #(.NTAG(NTAG)) u_tags (
    .clk(clk), .rst_n(rst_n), .alloc(iss_valid && iss_ready),
    .alloc_spec(guess_open), .commit(commit), .kill(flush),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .next_tag(iss_tag),
    .tag_free(tag_free), .wb_grant(wb_ready)
  );

  assign iss_pc   = head.pc;
  assign iss_unit = head.kind;
  assign iss_spec = guess_open;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      guess_q <= 1'b0;
      other_q <= '0;
    end else if (guess_set) begin
      open_q  <= 1'b1;
      guess_q <= guess_taken;
      other_q <= other_pc;
    end else if (res_valid) begin
      open_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/spec_branch_dispatch_chk.sv
module spec_branch_dispatch_chk #(
  parameter int PC_W  = 32,
  parameter int TAG_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iss_valid,
  input logic             iss_ready,
  input logic [PC_W-1:0]  iss_pc,
  input logic [2:0]       iss_unit,
  input logic [TAG_W-1:0] iss_tag,
  input logic             iss_spec,
  input logic             wb_valid,
  input logic             wb_ready,
  input logic             flush,
  input logic             redir_valid
);
  // R10
  flush_blocks_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !iss_valid);
  // R10
  flush_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush);
  // R10
  flush_redirects_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> redir_valid);
  // R6
  grant_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_ready |-> wb_valid);
  // R2
  offer_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |=> (flush ||
      (iss_valid && $stable(iss_pc) && $stable(iss_unit) && $stable(iss_tag))));
  // R7
  bru_never_spec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_unit == 3'd4) |-> !iss_spec);
endmodule

bind spec_branch_dispatch spec_branch_dispatch_chk #(.PC_W(sbd_pkg::PC_W), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
  .iss_pc(iss_pc), .iss_unit(iss_unit), .iss_tag(iss_tag), .iss_spec(iss_spec),
  .wb_valid(wb_valid), .wb_ready(wb_ready), .flush(flush), .redir_valid(redir_valid)
);

// File: tb/spec_branch_dispatch_tb.sv
module spec_branch_dispatch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NTAG = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [31:0] in_pc = '0;
  logic [15:0] in_disp = '0;
  logic [2:0]  in_kind = '0;
  logic        in_hint = 1'b0, in_known = 1'b0, in_outcome = 1'b0;
  logic        iss_valid, iss_ready = 1'b1;
  logic [31:0] iss_pc;
  logic [2:0]  iss_unit;
  logic [2:0]  iss_tag;
  logic        iss_spec;
  logic        wb_valid = 1'b0;
  logic [2:0]  wb_tag = '0;
  logic        wb_ready;
  logic        res_valid = 1'b0, res_taken = 1'b0;
  logic        flush, redir_valid;
  logic [31:0] redir_pc;

  int n_chk = 0;
  int n_bad = 0;
  logic [2:0] exp_tag = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_branch_dispatch #(.QDEPTH(4), .NTAG(NTAG), .PC_STEP(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pc(in_pc), .in_disp(in_disp), .in_kind(in_kind), .in_hint(in_hint),
    .in_known(in_known), .in_outcome(in_outcome), .iss_valid(iss_valid),
    .iss_ready(iss_ready), .iss_pc(iss_pc), .iss_unit(iss_unit),
    .iss_tag(iss_tag), .iss_spec(iss_spec), .wb_valid(wb_valid),
    .wb_tag(wb_tag), .wb_ready(wb_ready), .res_valid(res_valid),
    .res_taken(res_taken), .flush(flush), .redir_valid(redir_valid),
    .redir_pc(redir_pc)
  );

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic offer(input logic [2:0] k, input logic [31:0] pc,
                       input logic [15:0] d, input logic h,
                       input logic kn, input logic oc);
    in_kind = k; in_pc = pc; in_disp = d;
    in_hint = h; in_known = kn; in_outcome = oc;
    in_valid = 1'b1;
  endtask

  task automatic push(input logic [2:0] k, input logic [31:0] pc,
                      input logic [15:0] d, input logic h,
                      input logic kn, input logic oc);
    offer(k, pc, d, h, kn, oc);
    tick();
    in_valid = 1'b0;
    #1;
  endtask

  function automatic logic [31:0] tgt(input logic [31:0] pc, input logic [15:0] d);
    return pc + {{16{d[15]}}, d};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check(in_ready && !iss_valid && !redir_valid && !flush, "R1 idle",
          {in_ready, iss_valid, redir_valid, flush}, 4'b1000);
    wb_valid = 1'b1; wb_tag = 3'd0; #1;
    check(!wb_ready, "R1 no grant", wb_ready, 0);
    wb_valid = 1'b0;

    // R2 in-order issue and hold
    iss_ready = 1'b0;
    push(3'd0, 32'h100, 16'h0, 0, 0, 0);
    push(3'd1, 32'h104, 16'h0, 0, 0, 0);
    check(iss_valid && iss_pc == 32'h100 && iss_unit == 3'd0 && iss_tag == 3'd0 && !iss_spec,
          "R2 first offer", iss_pc, 32'h100);
    tick(); #1;
    check(iss_valid && iss_pc == 32'h100 && iss_tag == 3'd0, "R2 held", iss_pc, 32'h100);
    iss_ready = 1'b1;
    tick(); #1;
    check(iss_valid && iss_pc == 32'h104 && iss_unit == 3'd1 && iss_tag == 3'd1,
          "R2 second", {iss_pc, 5'b0, iss_unit}, {32'h104, 8'd1});
    tick(); #1;
    check(!iss_valid, "R2 drained", iss_valid, 0);
    wb_valid = 1'b1; wb_tag = 3'd0; #1;
    check(wb_ready, "R6 nonspec grant", wb_ready, 1);
    tick(); wb_tag = 3'd1; #1;
    check(wb_ready, "R6 nonspec grant", wb_ready, 1);
    tick(); wb_valid = 1'b0;
    exp_tag = 3'd2;

    // R3 jump folding, younger dropped; R12 push during redirect dropped
    iss_ready = 1'b0;
    push(3'd0, 32'h200, 16'h0, 0, 0, 0);
    push(3'd5, 32'h204, 16'h0040, 0, 0, 0);
    push(3'd0, 32'h208, 16'h0, 0, 0, 0);
    iss_ready = 1'b1;
    tick();
    exp_tag = exp_tag + 1'b1;
    offer(3'd0, 32'h300, 16'h0, 0, 0, 0);
    #1;
    check(redir_valid && redir_pc == 32'h244 && !iss_valid, "R3 jump redirect", redir_pc, 32'h244);
    tick(); in_valid = 1'b0; #1;
    check(!iss_valid && !redir_valid, "R3 younger dropped", iss_valid, 0);
    check(!iss_valid, "R12 beat during redirect dropped", iss_valid, 0);
    wb_valid = 1'b1; wb_tag = 3'd2; #1;
    check(wb_ready, "R6 grant", wb_ready, 1);
    tick(); wb_valid = 1'b0;

    // R4 known conditional
    push(3'd6, 32'h400, 16'h0010, 0, 1, 1);
    check(redir_valid && redir_pc == 32'h410 && !iss_valid, "R4 known taken", redir_pc, 32'h410);
    tick(); #1;
    check(!redir_valid, "R4 redirect one cycle", redir_valid, 0);
    push(3'd6, 32'h500, 16'h0010, 0, 1, 0);
    offer(3'd0, 32'h504, 16'h0, 0, 0, 0);
    #1;
    check(!redir_valid && !iss_valid, "R4 known not taken", redir_valid, 0);
    tick(); in_valid = 1'b0; #1;
    check(iss_valid && iss_pc == 32'h504 && iss_tag == exp_tag, "R4 next issues",
          iss_pc, 32'h504);
    tick();
    wb_valid = 1'b1; wb_tag = exp_tag; #1;
    check(wb_ready, "R6 grant", wb_ready, 1);
    tick(); wb_valid = 1'b0;
    exp_tag = exp_tag + 1'b1;

    // R5 R6 R7 R9 R10 sweep: displacement sign x hint x actual direction
    for (int i = 0; i < 8; i++) begin
      logic neg, hnt, act, pred;
      logic [31:0] pc, p2, t;
      logic [15:0] d;
      logic [2:0] stag;
      neg = i[2]; hnt = i[1]; act = i[0];
      pred = neg ^ hnt;
      pc = 32'h1000 + 32'(i) * 32'h100;
      p2 = 32'h8000 + 32'(i) * 32'h10;
      d  = neg ? 16'hFFC0 : 16'h0040;
      t  = tgt(pc, d);
      push(3'd6, pc, d, hnt, 0, 0);
      check(redir_valid == pred && (!pred || redir_pc == t) && !iss_valid, "R5 static guess",
            {redir_valid, redir_pc}, {pred, t});
      tick();
      push(3'd0, p2, 16'h0, 0, 0, 0);
      check(iss_valid && iss_spec && iss_tag == exp_tag, "R6 spec mark",
            {iss_spec, iss_tag}, {1'b1, exp_tag});
      stag = exp_tag;
      tick();
      exp_tag = exp_tag + 1'b1;
      push(3'd4, p2 + 32'h4, 16'h0, 0, 0, 0);
      check(!iss_valid, "R7 bru held", iss_valid, 0);
      push(3'd6, p2 + 32'h8, 16'h0010, 0, 0, 0);
      wb_valid = 1'b1; wb_tag = stag; #1;
      check(!wb_ready, "R6 spec write-back held", wb_ready, 0);
      res_valid = 1'b1; res_taken = act; #1;
      if (act == pred) begin
        check(!flush && iss_valid && iss_unit == 3'd4 && !iss_spec && iss_tag == exp_tag,
              "R9 issue in resolve cycle", {flush, iss_valid, iss_spec}, 3'b010);
        tick(); res_valid = 1'b0;
        exp_tag = exp_tag + 1'b1;
        #1;
        check(wb_ready, "R9 held write-back released", wb_ready, 1);
        tick();
        wb_tag = exp_tag - 1'b1; #1;
        check(wb_ready, "R9 bru write-back", wb_ready, 1);
        res_valid = 1'b1; res_taken = 1'b0;
        tick(); res_valid = 1'b0; wb_valid = 1'b0;
      end else begin
        check(flush && redir_valid && !iss_valid &&
              redir_pc == (pred ? pc + 32'h4 : t), "R10 flush redirect",
              redir_pc, pred ? pc + 32'h4 : t);
        tick(); res_valid = 1'b0; #1;
        check(!flush && !iss_valid, "R10 queue emptied", {flush, iss_valid}, 0);
        check(!wb_ready, "R10 killed tag refused", wb_ready, 0);
        wb_valid = 1'b0;
      end
    end

    // R8 second unresolved conditional stalls
    push(3'd6, 32'h3000, 16'h0010, 0, 0, 0);
    tick();
    push(3'd6, 32'h3004, 16'hFFC0, 0, 0, 0);
    check(!redir_valid && !iss_valid, "R8 stall", redir_valid, 0);
    push(3'd0, 32'h3008, 16'h0, 0, 0, 0);
    check(!redir_valid && !iss_valid, "R8 still stalled", redir_valid, 0);
    res_valid = 1'b1; res_taken = 1'b0; #1;
    check(redir_valid && !flush && redir_pc == 32'h2FC4, "R8 guessed on resolve",
          redir_pc, 32'h2FC4);
    tick(); res_taken = 1'b1; #1;
    check(!flush && !iss_valid, "R8 resolved correct", {flush, iss_valid}, 0);
    tick(); res_valid = 1'b0;

    // R11 tag reuse stall
    for (int k = 0; k < NTAG; k++) begin
      push(3'd2, 32'h4000 + 32'(k) * 4, 16'h0, 0, 0, 0);
      check(iss_valid && iss_tag == exp_tag + 3'(k), "R11 cyclic tag",
            iss_tag, exp_tag + 3'(k));
    end
    tick();
    push(3'd2, 32'h4100, 16'h0, 0, 0, 0);
    check(!iss_valid, "R11 stall on busy tag", iss_valid, 0);
    wb_valid = 1'b1; wb_tag = exp_tag; #1;
    check(wb_ready, "R11 retire", wb_ready, 1);
    tick(); wb_valid = 1'b0; #1;
    check(iss_valid && iss_tag == exp_tag && iss_pc == 32'h4100, "R11 reuse", iss_tag, exp_tag);
    tick();

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule